// File: doc/BRIEF.md
# USB Endpoint Handshake Controller

This block chooses the handshake a low-speed USB device returns on the bus. The device has one control endpoint (endpoint 0) and two interrupt endpoints (1 and 2) that only transmit. A serial interface engine sits in front of the block and does the bit-level work. It hands over decoded events, each as a one-cycle strobe: a token (PID, device address, endpoint number), a data packet (DATA0/DATA1, byte count, CRC result) and a host acknowledge.

From these events the block selects one response: send data with DATA0 or DATA1, ACK, NAK, STALL, or stay silent. It also keeps the registers that firmware reads. These are the receive-ready and transmit-ready bits, the interrupt flags, the received byte count, and a small status record. Firmware sets the policy bits (stall, configuration, the control-read guard, toggles and transmit counts). It then only re-arms the ready bits and clears the flags. Every other decision is made here without firmware help.

The response appears one clock after the event that caused it and lasts one clock. The engine then serialises it. When `rx_store` pulses, the engine writes the received bytes into the receive buffer.

Top module: `usb_ep_handshake`

## Requirements
- R1: The device address register resets to 0 and loads `fw_addr_wdata` when `fw_addr_we` is 1. A token whose address differs from the register gives no response and changes no ready bit, flag or status field.
- R2: When a SETUP token to endpoint 0 is followed by a data packet with a good CRC, the block answers ACK, pulses `rx_store`, loads `rx_cnt`, sets `st_setup`=1, `st_dir`=0 and `st_tgl`, clears `rx_rdy` and sets `irq_rx`. The stall bit and `rx_rdy` have no effect on this.
- R3: An OUT data packet to endpoint 0 with a good CRC is accepted when `rx_rdy`=1, stall is 0 and the R8 guard does not apply. Acceptance gives ACK, pulses `rx_store`, loads `rx_cnt` and `st_tgl`, sets `st_setup`=0 and `st_dir`=0, clears `rx_rdy` and sets `irq_rx`.
- R4: An endpoint 0 OUT packet that reaches the ready test while `rx_rdy`=0 is answered NAK, and nothing is stored.
- R5: An IN token to a present endpoint is answered in one of three ways. With the stall bit at 1 the answer is STALL. With the stall bit at 0 and transmit-ready at 1 the answer is data: DATA1 when the endpoint's toggle is 1, DATA0 when it is 0, and `resp_len` = min(count, 8). Otherwise the answer is NAK. An IN token to endpoint 0 sets `st_dir`=1 and `st_setup`=0.
- R6: A host acknowledge that follows a data response clears that endpoint's transmit-ready bit and sets its `irq_tx` bit. A host acknowledge at any other time has no effect.
- R7: Endpoints 1 and 2 respond to IN only while their `ep_cfg` bit is 1 (bit 0 for endpoint 1, bit 1 for endpoint 2). OUT or SETUP to endpoints 1 to 3, and IN to endpoint 3, get no response and no storing.
- R8: While `ctl_read`=1, an endpoint 0 OUT carrying DATA0 or a nonzero byte count is answered STALL. A zero-length DATA1 packet continues to the R3/R4 rules.
- R9: With the endpoint 0 stall bit at 1, endpoint 0 OUT data is answered STALL before the guard and ready tests, and `rx_rdy` is kept.
- R10: A data packet with a bad CRC gets no response, sets `st_err`=1, leaves `rx_rdy` unchanged and stores nothing. A later stored packet clears `st_err`.
- R11: `fw_rx_arm` and `fw_tx_arm[i]` set the ready bits. `fw_rx_irq_clr` and `fw_tx_irq_clr[i]` clear the flags. When a hardware update lands in the same cycle as one of these firmware writes, the hardware update wins.
- R12: Tokens are coded on `tok_pid` as OUT=0, IN=1, SETUP=2, and 3 gets no response. Responses are coded on `resp_kind` as NONE=0, ACK=1, NAK=2, STALL=3, DATA0=4, DATA1=5. A response is present for exactly the one cycle after its event. Otherwise `resp_kind`, `resp_ep` and `resp_len` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | Token event strobe |
| tok_pid | input | 2 | Token kind: OUT=0, IN=1, SETUP=2 |
| tok_addr | input | 7 | Device address carried by the token |
| tok_ep | input | 2 | Endpoint number carried by the token |
| dat_valid | input | 1 | Data packet event strobe |
| dat_pid1 | input | 1 | 1 for DATA1, 0 for DATA0 |
| dat_cnt | input | 4 | Received byte count |
| dat_crc_ok | input | 1 | 1 when the packet CRC is good |
| host_ack | input | 1 | Host ACK strobe after an IN data packet |
| fw_addr_we | input | 1 | Write strobe for the address register |
| fw_addr_wdata | input | 7 | New device address |
| fw_rx_arm | input | 1 | Sets endpoint 0 receive-ready |
| fw_tx_arm | input | 3 | Sets transmit-ready, one bit per endpoint |
| fw_rx_irq_clr | input | 1 | Clears the receive interrupt flag |
| fw_tx_irq_clr | input | 3 | Clears the transmit interrupt flags |
| ep_stall | input | 3 | Stall bit per endpoint |
| ep_cfg | input | 2 | Enable bits for endpoints 1 and 2 |
| ctl_read | input | 1 | Control-read guard enable |
| tx_tgl | input | 3 | Transmit toggle per endpoint |
| tx_cnt | input | 12 | Transmit byte count, 4 bits per endpoint, endpoint 0 lowest |
| resp_kind | output | 3 | Selected handshake code |
| resp_ep | output | 2 | Endpoint of the response |
| resp_len | output | 4 | Bytes to send with a data response |
| rx_store | output | 1 | Pulse: write received bytes to the receive buffer |
| rx_cnt | output | 4 | Stored byte count of the last accepted packet |
| rx_rdy | output | 1 | Endpoint 0 receive-ready |
| tx_rdy | output | 3 | Transmit-ready per endpoint |
| irq_rx | output | 1 | Receive interrupt flag |
| irq_tx | output | 3 | Transmit interrupt flags |
| st_dir | output | 1 | Last endpoint 0 direction, 1 for IN |
| st_setup | output | 1 | Last stored packet followed SETUP |
| st_tgl | output | 1 | Toggle of the last stored packet |
| st_err | output | 1 | CRC error seen since the last stored packet |

## Verification
Some properties are checked on every cycle. `rx_rdy` can fall only when a store pulse happens. A transmit-ready bit can fall only when its interrupt flag is set. A data response only follows a transmit-ready bit that was already set, and its length never exceeds eight. A CRC-error rise never comes with a handshake. Which response wins when stall, the control-read guard and the ready bit interact can only be shown by the bench's scenarios. The same holds for SETUP overriding stall, unconfigured endpoints staying silent, the address filter, and a hardware flag set beating a firmware clear in the same cycle. In those scenarios a behavioural model is compared against the outputs on every clock.

// File: rtl/usbhs_pkg.sv
package usbhs_pkg;

    typedef enum logic [1:0] {
        TK_OUT   = 2'd0,
        TK_IN    = 2'd1,
        TK_SETUP = 2'd2,
        TK_RSVD  = 2'd3
    } tok_e;

    typedef enum logic [2:0] {
        HS_NONE  = 3'd0,
        HS_ACK   = 3'd1,
        HS_NAK   = 3'd2,
        HS_STALL = 3'd3,
        HS_DATA0 = 3'd4,
        HS_DATA1 = 3'd5
    } hs_e;

    typedef enum logic [1:0] {
        PH_IDLE      = 2'd0,
        PH_WAIT_DATA = 2'd1,
        PH_WAIT_ACK  = 2'd2
    } phase_e;

endpackage

// File: rtl/usbhs_addr_reg.sv
module usbhs_addr_reg #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] wdata,
    input  logic [ADDR_W-1:0] tok_addr,
    output logic              match
);
    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = we ? wdata : addr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    // the compare uses the register value from before any same-cycle write
    assign match = (tok_addr == addr_q);

    p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(addr_q));

endmodule

// File: rtl/usbhs_in_sel.sv
module usbhs_in_sel
    import usbhs_pkg::*;
#(
    parameter int N_EP    = 3,
    parameter int EPN_W   = 2,
    parameter int CNT_W   = 4,
    parameter int MAX_LEN = 8,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic [EPN_W-1:0]      ep,
    input  logic [N_EP-1:0]       present,
    input  logic [N_EP-1:0]       tx_rdy,
    input  logic [N_EP-1:0]       stall,
    input  logic [N_EP-1:0]       tgl,
    input  logic [N_EP*CNT_W-1:0] cnt_flat,
    output hs_e                   kind,
    output logic [LEN_W-1:0]      len,
    output logic                  send
);
    logic [N_EP-1:0] hit_v;
    logic [LEN_W-1:0] len_a [N_EP];

    for (genvar i = 0; i < N_EP; i++) begin : g_ep
        logic [CNT_W-1:0] cnt_c;
        assign cnt_c    = cnt_flat[i*CNT_W +: CNT_W];
        assign hit_v[i] = present[i] && (ep == EPN_W'(i));
        assign len_a[i] = (cnt_c > CNT_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : LEN_W'(cnt_c);
    end

    always_comb begin
        kind = HS_NONE;
        len  = '0;
        send = 1'b0;
        for (int i = 0; i < N_EP; i++) begin
            if (hit_v[i]) begin
                if (stall[i]) begin
                    kind = HS_STALL;
                end else if (tx_rdy[i]) begin
                    kind = tgl[i] ? HS_DATA1 : HS_DATA0;
                    len  = len_a[i];
                    send = 1'b1;
                end else begin
                    kind = HS_NAK;
                end
            end
        end
    end

endmodule

// File: rtl/usbhs_out_sel.sv
module usbhs_out_sel
    import usbhs_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             setup,
    input  logic             crc_ok,
    input  logic             pid1,
    input  logic [CNT_W-1:0] cnt,
    input  logic             stall0,
    input  logic             ctl_read,
    input  logic             rx_rdy,
    output hs_e              kind,
    output logic             store,
    output logic             crc_bad
);
    always_comb begin
        kind    = HS_NONE;
        store   = 1'b0;
        crc_bad = 1'b0;
        if (!crc_ok) begin
            crc_bad = 1'b1;
        end else if (setup) begin
            kind  = HS_ACK;
            store = 1'b1;
        end else if (stall0) begin
            kind = HS_STALL;
        end else if (ctl_read && (!pid1 || cnt != '0)) begin
            kind = HS_STALL;
        end else if (!rx_rdy) begin
            kind = HS_NAK;
        end else begin
            kind  = HS_ACK;
            store = 1'b1;
        end
    end

endmodule

// File: rtl/usb_ep_handshake.sv
module usb_ep_handshake
    import usbhs_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int EPN_W   = 2,
    parameter int N_EP    = 3,
    parameter int CNT_W   = 4,
    parameter int MAX_LEN = 8,
    localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tok_valid,
    input  logic [1:0]            tok_pid,
    input  logic [ADDR_W-1:0]     tok_addr,
    input  logic [EPN_W-1:0]      tok_ep,
    input  logic                  dat_valid,
    input  logic                  dat_pid1,
    input  logic [CNT_W-1:0]      dat_cnt,
    input  logic                  dat_crc_ok,
    input  logic                  host_ack,
    input  logic                  fw_addr_we,
    input  logic [ADDR_W-1:0]     fw_addr_wdata,
    input  logic                  fw_rx_arm,
    input  logic [N_EP-1:0]       fw_tx_arm,
    input  logic                  fw_rx_irq_clr,
    input  logic [N_EP-1:0]       fw_tx_irq_clr,
    input  logic [N_EP-1:0]       ep_stall,
    input  logic [N_EP-2:0]       ep_cfg,
    input  logic                  ctl_read,
    input  logic [N_EP-1:0]       tx_tgl,
    input  logic [N_EP*CNT_W-1:0] tx_cnt,
    output logic [2:0]            resp_kind,
    output logic [EPN_W-1:0]      resp_ep,
    output logic [LEN_W-1:0]      resp_len,
    output logic                  rx_store,
    output logic [CNT_W-1:0]      rx_cnt,
    output logic                  rx_rdy,
    output logic [N_EP-1:0]       tx_rdy,
    output logic                  irq_rx,
    output logic [N_EP-1:0]       irq_tx,
    output logic                  st_dir,
    output logic                  st_setup,
    output logic                  st_tgl,
    output logic                  st_err
);
    typedef struct packed {
        phase_e           phase;
        logic             setup_pend;
        logic [EPN_W-1:0] ack_ep;
        logic             rx_rdy;
        logic [N_EP-1:0]  tx_rdy;
        logic             irq_rx;
        logic [N_EP-1:0]  irq_tx;
        logic             st_dir;
        logic             st_setup;
        logic             st_tgl;
        logic             st_err;
        logic [CNT_W-1:0] rx_cnt;
        hs_e              kind;
        logic [EPN_W-1:0] ep;
        logic [LEN_W-1:0] len;
        logic             store;
    } state_t;

    state_t s_d, s_q;

    logic             addr_hit;
    hs_e              in_kind, out_kind;
    logic [LEN_W-1:0] in_len;
    logic             in_send, out_store, out_crc_bad;
    logic [N_EP-1:0]  present;

    assign present = {ep_cfg, 1'b1};

    usbhs_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .we(fw_addr_we), .wdata(fw_addr_wdata),
        .tok_addr(tok_addr), .match(addr_hit)
    );

    usbhs_in_sel #(.N_EP(N_EP), .EPN_W(EPN_W), .CNT_W(CNT_W), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_in (
        .ep(tok_ep), .present(present), .tx_rdy(s_q.tx_rdy), .stall(ep_stall),
        .tgl(tx_tgl), .cnt_flat(tx_cnt), .kind(in_kind), .len(in_len), .send(in_send)
    );

    usbhs_out_sel #(.CNT_W(CNT_W)) u_out (
        .setup(s_q.setup_pend), .crc_ok(dat_crc_ok), .pid1(dat_pid1), .cnt(dat_cnt),
        .stall0(ep_stall[0]), .ctl_read(ctl_read), .rx_rdy(s_q.rx_rdy),
        .kind(out_kind), .store(out_store), .crc_bad(out_crc_bad)
    );

    always_comb begin
        s_d       = s_q;
        s_d.kind  = HS_NONE;
        s_d.ep    = '0;
        s_d.len   = '0;
        s_d.store = 1'b0;
        // firmware writes first; bus events below take precedence
        if (fw_rx_arm)     s_d.rx_rdy = 1'b1;
        if (fw_rx_irq_clr) s_d.irq_rx = 1'b0;
        s_d.tx_rdy = s_q.tx_rdy | fw_tx_arm;
        s_d.irq_tx = s_q.irq_tx & ~fw_tx_irq_clr;

        if (tok_valid) begin
            s_d.phase = PH_IDLE;
            if (addr_hit) begin
                if (tok_pid == TK_IN) begin
                    s_d.kind = in_kind;
                    s_d.len  = in_len;
                    s_d.ep   = (in_kind != HS_NONE) ? tok_ep : '0;
                    if (in_send) begin
                        s_d.phase  = PH_WAIT_ACK;
                        s_d.ack_ep = tok_ep;
                    end
                    if (tok_ep == '0) begin
                        s_d.st_dir   = 1'b1;
                        s_d.st_setup = 1'b0;
                    end
                end else if ((tok_pid == TK_OUT || tok_pid == TK_SETUP) && tok_ep == '0) begin
                    s_d.phase      = PH_WAIT_DATA;
                    s_d.setup_pend = (tok_pid == TK_SETUP);
                end
            end
        end else if (dat_valid && s_q.phase == PH_WAIT_DATA) begin
            s_d.phase = PH_IDLE;
            s_d.kind  = out_kind;
            if (out_crc_bad) s_d.st_err = 1'b1;
            if (out_store) begin
                s_d.store    = 1'b1;
                s_d.rx_cnt   = dat_cnt;
                s_d.st_tgl   = dat_pid1;
                s_d.st_setup = s_q.setup_pend;
                s_d.st_dir   = 1'b0;
                s_d.st_err   = 1'b0;
                s_d.rx_rdy   = 1'b0;
                s_d.irq_rx   = 1'b1;
            end
        end else if (host_ack && s_q.phase == PH_WAIT_ACK) begin
            s_d.phase = PH_IDLE;
            for (int i = 0; i < N_EP; i++) begin
                if (s_q.ack_ep == EPN_W'(i)) begin
                    s_d.tx_rdy[i] = 1'b0;
                    s_d.irq_tx[i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign resp_kind = s_q.kind;
    assign resp_ep   = s_q.ep;
    assign resp_len  = s_q.len;
    assign rx_store  = s_q.store;
    assign rx_cnt    = s_q.rx_cnt;
    assign rx_rdy    = s_q.rx_rdy;
    assign tx_rdy    = s_q.tx_rdy;
    assign irq_rx    = s_q.irq_rx;
    assign irq_tx    = s_q.irq_tx;
    assign st_dir    = s_q.st_dir;
    assign st_setup  = s_q.st_setup;
    assign st_tgl    = s_q.st_tgl;
    assign st_err    = s_q.st_err;

    p_rdy_fall_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.rx_rdy) |-> s_q.store);

    p_refuse_no_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.kind == HS_NAK || s_q.kind == HS_STALL) |-> !s_q.store);

    p_data_had_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.kind == HS_DATA0 || s_q.kind == HS_DATA1) |->
            (|($past(s_q.tx_rdy) & (N_EP'(1) << s_q.ep))) && (int'(s_q.len) <= MAX_LEN));

    p_err_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.st_err) |-> (s_q.kind == HS_NONE && !s_q.store));

    p_len_only_data_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.kind == HS_DATA0 || s_q.kind == HS_DATA1) |-> s_q.len == '0);

    for (genvar i = 0; i < N_EP; i++) begin : g_chk
        p_tx_fall_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(s_q.tx_rdy[i]) |-> s_q.irq_tx[i]);
    end

endmodule

// File: tb/sim_usb_ep_handshake.sv
module sim_usb_ep_handshake;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        tok_valid = 0, dat_valid = 0, dat_pid1 = 0, dat_crc_ok = 1, host_ack = 0;
    logic [1:0]  tok_pid = 0, tok_ep = 0;
    logic [6:0]  tok_addr = 0, fw_addr_wdata = 0;
    logic [3:0]  dat_cnt = 0;
    logic        fw_addr_we = 0, fw_rx_arm = 0, fw_rx_irq_clr = 0, ctl_read = 0;
    logic [2:0]  fw_tx_arm = 0, fw_tx_irq_clr = 0, ep_stall = 0, tx_tgl = 0;
    logic [1:0]  ep_cfg = 0;
    logic [11:0] tx_cnt = 0;

    logic [2:0] resp_kind, tx_rdy, irq_tx;
    logic [1:0] resp_ep;
    logic [3:0] resp_len, rx_cnt;
    logic       rx_store, rx_rdy, irq_rx, st_dir, st_setup, st_tgl, st_err;

    usb_ep_handshake u0 (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_pid(tok_pid), .tok_addr(tok_addr),
        .tok_ep(tok_ep), .dat_valid(dat_valid), .dat_pid1(dat_pid1), .dat_cnt(dat_cnt),
        .dat_crc_ok(dat_crc_ok), .host_ack(host_ack), .fw_addr_we(fw_addr_we),
        .fw_addr_wdata(fw_addr_wdata), .fw_rx_arm(fw_rx_arm), .fw_tx_arm(fw_tx_arm),
        .fw_rx_irq_clr(fw_rx_irq_clr), .fw_tx_irq_clr(fw_tx_irq_clr), .ep_stall(ep_stall),
        .ep_cfg(ep_cfg), .ctl_read(ctl_read), .tx_tgl(tx_tgl), .tx_cnt(tx_cnt),
        .resp_kind(resp_kind), .resp_ep(resp_ep), .resp_len(resp_len), .rx_store(rx_store),
        .rx_cnt(rx_cnt), .rx_rdy(rx_rdy), .tx_rdy(tx_rdy), .irq_rx(irq_rx), .irq_tx(irq_tx),
        .st_dir(st_dir), .st_setup(st_setup), .st_tgl(st_tgl), .st_err(st_err)
    );

    int n_chk = 0, n_err = 0;
    bit done = 0;
    string cur_req = "R12";

    // behavioural reference model
    int m_addr, m_phase, m_setup, m_ackep, m_rxrdy, m_irqrx, m_dir, m_set, m_tgl, m_err, m_cnt;
    int m_kind, m_ep, m_len, m_store;
    bit [2:0] m_txrdy, m_irqtx;

    always @(posedge clk) begin : model
        int k, e, l, s, a_old, rr_old, ep, cnt;
        bit [2:0] tr_old;
        bit exists, take;
        if (!rst_n) begin
            m_addr = 0; m_phase = 0; m_setup = 0; m_ackep = 0; m_rxrdy = 0; m_irqrx = 0;
            m_dir = 0; m_set = 0; m_tgl = 0; m_err = 0; m_cnt = 0;
            m_kind = 0; m_ep = 0; m_len = 0; m_store = 0; m_txrdy = 0; m_irqtx = 0;
        end else begin
            k = 0; e = 0; l = 0; s = 0;
            a_old = m_addr; rr_old = m_rxrdy; tr_old = m_txrdy;
            if (fw_addr_we) m_addr = fw_addr_wdata;
            if (fw_rx_arm) m_rxrdy = 1;
            if (fw_rx_irq_clr) m_irqrx = 0;
            m_txrdy = m_txrdy | fw_tx_arm;
            m_irqtx = m_irqtx & ~fw_tx_irq_clr;
            if (tok_valid) begin
                m_phase = 0;
                if (int'(tok_addr) == a_old) begin
                    ep = int'(tok_ep);
                    if (tok_pid == 2'd1) begin
                        exists = (ep == 0) || (ep == 1 && ep_cfg[0]) || (ep == 2 && ep_cfg[1]);
                        if (exists) begin
                            if (ep_stall[ep]) k = 3;
                            else if (tr_old[ep]) begin
                                k = tx_tgl[ep] ? 5 : 4;
                                cnt = int'(tx_cnt[ep*4 +: 4]);
                                l = (cnt > 8) ? 8 : cnt;
                                m_phase = 2; m_ackep = ep;
                            end else k = 2;
                            e = ep;
                        end
                        if (ep == 0) begin m_dir = 1; m_set = 0; end
                    end else if ((tok_pid == 2'd0 || tok_pid == 2'd2) && ep == 0) begin
                        m_phase = 1; m_setup = (tok_pid == 2'd2) ? 1 : 0;
                    end
                end
            end else if (dat_valid && m_phase == 1) begin
                m_phase = 0;
                if (!dat_crc_ok) m_err = 1;
                else begin
                    take = 0;
                    if (m_setup != 0) take = 1;
                    else if (ep_stall[0]) k = 3;
                    else if (ctl_read && (!dat_pid1 || dat_cnt != 0)) k = 3;
                    else if (rr_old == 0) k = 2;
                    else take = 1;
                    if (take) begin
                        k = 1; s = 1; m_cnt = int'(dat_cnt); m_tgl = int'(dat_pid1);
                        m_set = m_setup; m_dir = 0; m_err = 0; m_rxrdy = 0; m_irqrx = 1;
                    end
                end
            end else if (host_ack && m_phase == 2) begin
                m_phase = 0; m_txrdy[m_ackep] = 0; m_irqtx[m_ackep] = 1;
            end
            m_kind = k; m_ep = e; m_len = l; m_store = s;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        logic [25:0] act, exp;
        if (rst_n && !done) begin
            act = {resp_kind, resp_ep, resp_len, rx_store, rx_cnt, rx_rdy, tx_rdy, irq_rx, irq_tx,
                   st_dir, st_setup, st_tgl, st_err};
            exp = {3'(m_kind), 2'(m_ep), 4'(m_len), 1'(m_store), 4'(m_cnt), 1'(m_rxrdy), m_txrdy,
                   1'(m_irqrx), m_irqtx, 1'(m_dir), 1'(m_set), 1'(m_tgl), 1'(m_err)};
            n_chk++;
            if (act !== exp) begin
                n_err++;
                $display("FAIL %s cycle compare: actual=%h expected=%h", cur_req, act, exp);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tok(input int pid, input int addr, input int ep);
        tok_valid = 1; tok_pid = 2'(pid); tok_addr = 7'(addr); tok_ep = 2'(ep);
        @(negedge clk);
        tok_valid = 0;
    endtask

    task automatic dat(input bit pid1, input int cnt, input bit crc);
        dat_valid = 1; dat_pid1 = pid1; dat_cnt = 4'(cnt); dat_crc_ok = crc;
        @(negedge clk);
        dat_valid = 0; dat_crc_ok = 1;
    endtask

    task automatic hack();
        host_ack = 1;
        @(negedge clk);
        host_ack = 0;
    endtask

    task automatic rx_arm();
        fw_rx_arm = 1;
        @(negedge clk);
        fw_rx_arm = 0;
    endtask

    task automatic tx_arm(input int ep);
        fw_tx_arm = 3'(1 << ep);
        @(negedge clk);
        fw_tx_arm = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL R12 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state
        cur_req = "R12";
        chk("R12 reset resp", int'(resp_kind), 0);
        chk("R11 reset rdy", int'({rx_rdy, tx_rdy}), 0);
        chk("R11 reset irq", int'({irq_rx, irq_tx}), 0);

        // R1: address 0 after reset, then a new address
        cur_req = "R1";
        tok(1, 0, 0);
        chk("R1 default address answers", int'(resp_kind), 2);
        fw_addr_we = 1; fw_addr_wdata = 7'd5;
        @(negedge clk);
        fw_addr_we = 0;
        tok(1, 0, 0);
        chk("R1 old address ignored", int'(resp_kind), 0);
        tok(1, 5, 0);
        chk("R1 matched address NAK", int'(resp_kind), 2);
        @(negedge clk);
        chk("R12 one cycle response", int'(resp_kind), 0);

        // R5/R6: endpoint 0 IN data and host ack
        cur_req = "R5";
        tx_tgl = 3'b001; tx_cnt = 12'h003;
        tx_arm(0);
        tok(1, 5, 0);
        chk("R5 DATA1 kind", int'(resp_kind), 5);
        chk("R5 length", int'(resp_len), 3);
        chk("R5 direction in", int'(st_dir), 1);
        cur_req = "R6";
        hack();
        chk("R6 tx ready cleared", int'(tx_rdy[0]), 0);
        chk("R6 tx irq set", int'(irq_tx[0]), 1);
        hack();
        chk("R6 stray ack ignored", int'(irq_tx), 1);
        cur_req = "R11";
        fw_tx_irq_clr = 3'b001;
        @(negedge clk);
        fw_tx_irq_clr = 0;
        chk("R11 tx irq cleared", int'(irq_tx[0]), 0);
        cur_req = "R5";
        tx_tgl = 0; tx_cnt = 12'h00C;
        tx_arm(0);
        tok(1, 5, 0);
        chk("R5 DATA0 kind", int'(resp_kind), 4);
        chk("R5 length capped", int'(resp_len), 8);
        tok(1, 5, 0);
        chk("R5 no ack keeps ready", int'(tx_rdy[0]), 1);
        ep_stall = 3'b001;
        tok(1, 5, 0);
        chk("R5 IN stall", int'(resp_kind), 3);
        ep_stall = 0;
        hack();
        chk("R6 ack after stall ignored", int'(tx_rdy[0]), 1);

        // R4: OUT while not ready
        cur_req = "R4";
        tok(0, 5, 0);
        dat(1'b1, 2, 1'b1);
        chk("R4 NAK", int'(resp_kind), 2);
        chk("R4 no store", int'(rx_store), 0);

        // R3: accepted OUT
        cur_req = "R3";
        rx_arm();
        tok(0, 5, 0);
        dat(1'b1, 4, 1'b1);
        chk("R3 ACK", int'(resp_kind), 1);
        chk("R3 store", int'(rx_store), 1);
        chk("R3 count", int'(rx_cnt), 4);
        chk("R3 toggle", int'(st_tgl), 1);
        chk("R3 ready cleared", int'(rx_rdy), 0);
        chk("R3 irq set", int'(irq_rx), 1);
        chk("R3 direction out", int'(st_dir), 0);

        // R2: SETUP overrides stall and not-ready
        cur_req = "R2";
        ep_stall = 3'b001;
        tok(2, 5, 0);
        dat(1'b0, 8, 1'b1);
        chk("R2 ACK", int'(resp_kind), 1);
        chk("R2 store", int'(rx_store), 1);
        chk("R2 count", int'(rx_cnt), 8);
        chk("R2 setup flag", int'(st_setup), 1);

        // R9: stall on OUT, ready kept
        cur_req = "R9";
        rx_arm();
        tok(0, 5, 0);
        dat(1'b1, 0, 1'b1);
        chk("R9 STALL", int'(resp_kind), 3);
        chk("R9 ready kept", int'(rx_rdy), 1);
        ep_stall = 0;

        // R8: control-read guard
        cur_req = "R8";
        ctl_read = 1;
        tok(0, 5, 0);
        dat(1'b0, 0, 1'b1);
        chk("R8 DATA0 stalled", int'(resp_kind), 3);
        tok(0, 5, 0);
        dat(1'b1, 2, 1'b1);
        chk("R8 nonzero stalled", int'(resp_kind), 3);
        chk("R8 ready kept", int'(rx_rdy), 1);
        tok(0, 5, 0);
        dat(1'b1, 0, 1'b1);
        chk("R8 zero-length DATA1 ACK", int'(resp_kind), 1);
        chk("R8 setup flag clear", int'(st_setup), 0);
        ctl_read = 0;

        // R10: CRC error
        cur_req = "R10";
        rx_arm();
        tok(0, 5, 0);
        dat(1'b1, 3, 1'b0);
        chk("R10 silent", int'(resp_kind), 0);
        chk("R10 error flag", int'(st_err), 1);
        chk("R10 ready kept", int'(rx_rdy), 1);
        chk("R10 no store", int'(rx_store), 0);

        // R11: hardware set beats firmware clear
        cur_req = "R11";
        tok(0, 5, 0);
        dat_valid = 1; dat_pid1 = 0; dat_cnt = 1; fw_rx_irq_clr = 1;
        @(negedge clk);
        dat_valid = 0; fw_rx_irq_clr = 0;
        chk("R11 hw set wins", int'(irq_rx), 1);
        chk("R10 error cleared by store", int'(st_err), 0);
        fw_rx_irq_clr = 1;
        @(negedge clk);
        fw_rx_irq_clr = 0;
        chk("R11 rx irq cleared", int'(irq_rx), 0);

        // R7: endpoints 1 and 2
        cur_req = "R7";
        tx_cnt = 12'h020;
        tx_arm(1);
        tok(1, 5, 1);
        chk("R7 unconfigured silent", int'(resp_kind), 0);
        ep_cfg = 2'b01;
        tok(1, 5, 1);
        chk("R7 configured DATA0", int'(resp_kind), 4);
        chk("R7 endpoint", int'(resp_ep), 1);
        chk("R7 length", int'(resp_len), 2);
        hack();
        chk("R6 ep1 irq", int'(irq_tx), 2);
        tok(0, 5, 1);
        dat(1'b1, 1, 1'b1);
        chk("R7 OUT to ep1 silent", int'(resp_kind), 0);
        chk("R7 OUT to ep1 not stored", int'(rx_store), 0);
        tok(1, 5, 2);
        chk("R7 ep2 unconfigured", int'(resp_kind), 0);
        tok(1, 5, 3);
        chk("R7 ep3 silent", int'(resp_kind), 0);
        ep_cfg = 2'b10;
        tok(1, 5, 2);
        chk("R7 ep2 NAK", int'(resp_kind), 2);
        cur_req = "R12";
        tok(3, 5, 0);
        chk("R12 reserved pid silent", int'(resp_kind), 0);

        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule